// File: doc/BRIEF.md
# Privilege-Gated Chip-Select Unit

This block sits on the bus of an 8-bit processor, between the address decoder's chip-select lines and the peripherals they enable. It holds a single privilege bit outside the processor and a per-line protect mask. A line whose mask bit is set reaches its peripheral only while the privilege bit is set. Unmasked lines always pass, so applications keep direct access to fast I/O.

An unprivileged attempt to reach a protected line is blocked and latched in a sticky violation flag. The flag is not a bus-cycle trap: system-call entry code reads it and stops the offending application before any external state changes. Code that needs privilege writes a doorbell register. That write sets the privilege bit and pulls the active-low NMI line down for two qualified bus cycles. The NMI handler then runs as the only code in the system, which also makes it a global lock.

The registers occupy an 8-byte window at a parameterised base address. All state changes on `clk` edges that close a cycle in which `phi2` is high (a "qualified cycle").

Top module: `priv_cs_unit`

## Requirements
- R1: After synchronous reset the privilege bit is 1, the protect mask is all ones, the violation flag is 0, `nmi_n` is 1 and every `cs_out` line is 0.
- R2: The window covers `WIN_BASE` to `WIN_BASE+7`. While `phi2` is high and `rw` is 1, a read there drives `dout_en` high. Offset 0 returns status, with bit 0 holding privilege and bit 1 holding violation. Offset 2 returns the protect mask, one bit per line with bit i for line i. All other offsets read 0. Outside the window `dout_en` is 0.
- R3: In a qualified cycle with the privilege bit clear, any request on a line whose mask bit is 1 leaves that line's `cs_out` at 0 and sets the violation flag.
- R4: Lines whose mask bit is 0 always pass their request to `cs_out`. While privileged, every line passes.
- R5: `cs_out` is registered. After each `clk` edge it shows the gated request of the cycle just closed if `phi2` was high in that cycle, and 0 if `phi2` was low.
- R6: The violation flag stays set until a privileged write to offset 0 with data bit 1 equal to 1 clears it.
- R7: A qualified write to offset 1 sets the privilege bit and drives `nmi_n` low from the next edge. `nmi_n` returns high at the edge that closes the second qualified cycle after the write, and cycles with `phi2` low do not count.
- R8: A privileged write to offset 0 loads the privilege bit from data bit 0, which is how code drops privilege.
- R9: An unprivileged write to offset 0 or offset 2 changes neither the privilege bit nor the mask, and it sets the violation flag.
- R10: With `phi2` low, writes have no effect and protected requests do not set the violation flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| phi2 | input | 1 | Bus phase qualifier; high marks a valid bus cycle |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W | CPU address |
| din | input | DATA_W | Write data from the CPU |
| dout | output | DATA_W | Read data from the register window |
| dout_en | output | 1 | High when the unit drives read data |
| cs_in | input | N_CS | Decoded chip-select requests, active high |
| cs_out | output | N_CS | Gated, registered chip selects, active high |
| nmi_n | output | 1 | Non-maskable interrupt request, active low |

## Verification
The main sweep takes sixteen protect masks spread over the byte range. For each mask it runs all 256 request patterns in both the privileged and the unprivileged state. This separates masked from unmasked lines, shows that privilege lifts all gating, and shows that the violation flag follows exactly the patterns that overlap the mask. Directed sequences then cover the rest. They interleave a `phi2`-low cycle inside the NMI pulse to show that only qualified cycles are counted. They make unprivileged writes to the status and mask offsets, make writes with `phi2` low, and read offsets outside and inside the window to check the address decode.

// File: rtl/priv_cs_pkg.sv
package priv_cs_pkg;

    localparam int OFF_W      = 3;
    localparam logic [OFF_W-1:0] OFF_STATUS = 3'd0;
    localparam logic [OFF_W-1:0] OFF_DOOR   = 3'd1;
    localparam logic [OFF_W-1:0] OFF_MASK   = 3'd2;

    localparam int ST_PRIV_BIT = 0;
    localparam int ST_VIOL_BIT = 1;

    typedef struct packed {
        logic             rd;
        logic             wr_status;
        logic             wr_door;
        logic             wr_mask;
        logic [OFF_W-1:0] off;
    } reg_cmd_t;

    function automatic reg_cmd_t make_cmd(input logic hit, input logic qual,
                                          input logic rw, input logic [OFF_W-1:0] off);
        reg_cmd_t c;
        c.off       = off;
        c.rd        = hit && qual && rw;
        c.wr_status = hit && qual && !rw && (off == OFF_STATUS);
        c.wr_door   = hit && qual && !rw && (off == OFF_DOOR);
        c.wr_mask   = hit && qual && !rw && (off == OFF_MASK);
        return c;
    endfunction

endpackage

// File: rtl/pcs_decode.sv
module pcs_decode
    import priv_cs_pkg::*;
#(
    parameter int               ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'hBF80
) (
    input  logic              phi2,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    output reg_cmd_t          cmd
);
    localparam int TAG_W = ADDR_W - OFF_W;

    logic hit;
    assign hit = (addr[ADDR_W-1:OFF_W] == WIN_BASE[ADDR_W-1:OFF_W]);
    assign cmd = make_cmd(hit, phi2, rw, addr[OFF_W-1:0]);

    initial begin
        assert (TAG_W > 0) else $error("address too narrow for window");
    end
endmodule

// File: rtl/pcs_regs.sv
module pcs_regs
    import priv_cs_pkg::*;
#(
    parameter int N_CS   = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              phi2,
    input  reg_cmd_t          cmd,
    input  logic [DATA_W-1:0] din,
    input  logic [N_CS-1:0]   cs_in,
    output logic              priv,
    output logic [N_CS-1:0]   mask,
    output logic              door_fire,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    logic viol;
    logic prot_hit;
    logic bad_wr;
    logic viol_clr;

    assign prot_hit  = phi2 && !priv && |(cs_in & mask);
    assign bad_wr    = !priv && (cmd.wr_status || cmd.wr_mask);
    assign viol_clr  = priv && cmd.wr_status && din[ST_VIOL_BIT];
    assign door_fire = cmd.wr_door;

    always_ff @(posedge clk) begin
        if (rst) begin
            priv <= 1'b1;
            mask <= '1;
            viol <= 1'b0;
        end else begin
            if (cmd.wr_door)
                priv <= 1'b1;
            else if (cmd.wr_status && priv)
                priv <= din[ST_PRIV_BIT];
            if (cmd.wr_mask && priv)
                mask <= din[N_CS-1:0];
            if (prot_hit || bad_wr)
                viol <= 1'b1;
            else if (viol_clr)
                viol <= 1'b0;
        end
    end

    always_comb begin
        dout = '0;
        if (cmd.rd) begin
            case (cmd.off)
                OFF_STATUS: begin
                    dout[ST_PRIV_BIT] = priv;
                    dout[ST_VIOL_BIT] = viol;
                end
                OFF_MASK: dout[N_CS-1:0] = mask;
                default:  dout = '0;
            endcase
        end
    end
    assign dout_en = cmd.rd;

    initial begin
        assert (N_CS <= DATA_W) else $error("mask wider than data bus");
    end

    // R3: an unprivileged protected request latches the violation flag
    assert_prot_latch_R3: assert property (@(posedge clk) disable iff (rst)
        prot_hit |=> viol);
    // R6: the flag only falls through a privileged clearing write
    assert_viol_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (viol && !viol_clr) |=> viol);
    // R9: the mask cannot move while unprivileged
    assert_mask_locked_R9: assert property (@(posedge clk) disable iff (rst)
        !priv |=> $stable(mask));
    // R7: the doorbell always leaves the unit privileged
    assert_door_priv_R7: assert property (@(posedge clk) disable iff (rst)
        cmd.wr_door |=> priv);
endmodule

// File: rtl/pcs_nmi.sv
module pcs_nmi #(
    parameter int NMI_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic phi2,
    input  logic fire,
    output logic nmi_n
);
    localparam int CNT_W = $clog2(NMI_CYC + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (fire)
            cnt <= CNT_W'(NMI_CYC);
        else if (phi2 && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign nmi_n = (cnt == '0);

    // R7: a doorbell write pulls the line low at the next edge
    assert_nmi_start_R7: assert property (@(posedge clk) disable iff (rst)
        fire |=> !nmi_n);
    // R7: release only at the close of a qualified cycle
    assert_nmi_release_R7: assert property (@(posedge clk) disable iff (rst)
        (!nmi_n && !phi2 && !fire) |=> !nmi_n);
endmodule

// File: rtl/pcs_gate.sv
module pcs_gate #(
    parameter int N_CS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            phi2,
    input  logic            priv,
    input  logic [N_CS-1:0] mask,
    input  logic [N_CS-1:0] cs_in,
    output logic [N_CS-1:0] cs_out
);
    for (genvar i = 0; i < N_CS; i++) begin : g_line
        logic allow;
        assign allow = priv || !mask[i];

        always_ff @(posedge clk) begin
            if (rst)
                cs_out[i] <= 1'b0;
            else
                cs_out[i] <= phi2 && cs_in[i] && allow;
        end

        // R3: protected line stays quiet while unprivileged
        assert_blocked_R3: assert property (@(posedge clk) disable iff (rst)
            (phi2 && !priv && mask[i] && cs_in[i]) |=> !cs_out[i]);
        // R5: no select after a cycle without phi2
        assert_idle_R5: assert property (@(posedge clk) disable iff (rst)
            !phi2 |=> !cs_out[i]);
        // R4: unprotected request always passes
        assert_pass_R4: assert property (@(posedge clk) disable iff (rst)
            (phi2 && !mask[i] && cs_in[i]) |=> cs_out[i]);
    end
endmodule

// File: rtl/priv_cs_unit.sv
module priv_cs_unit
    import priv_cs_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter int                DATA_W   = 8,
    parameter int                N_CS     = 8,
    parameter int                NMI_CYC  = 2,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'hBF80
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              phi2,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    input  logic [N_CS-1:0]   cs_in,
    output logic [N_CS-1:0]   cs_out,
    output logic              nmi_n
);
    reg_cmd_t        cmd;
    logic            priv;
    logic [N_CS-1:0] mask;
    logic            door_fire;

    pcs_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_decode (
        .phi2 (phi2),
        .rw   (rw),
        .addr (addr),
        .cmd  (cmd)
    );

    pcs_regs #(.N_CS(N_CS), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .phi2      (phi2),
        .cmd       (cmd),
        .din       (din),
        .cs_in     (cs_in),
        .priv      (priv),
        .mask      (mask),
        .door_fire (door_fire),
        .dout      (dout),
        .dout_en   (dout_en)
    );

    pcs_nmi #(.NMI_CYC(NMI_CYC)) u_nmi (
        .clk   (clk),
        .rst   (rst),
        .phi2  (phi2),
        .fire  (door_fire),
        .nmi_n (nmi_n)
    );

    pcs_gate #(.N_CS(N_CS)) u_gate (
        .clk    (clk),
        .rst    (rst),
        .phi2   (phi2),
        .priv   (priv),
        .mask   (mask),
        .cs_in  (cs_in),
        .cs_out (cs_out)
    );

    // R1: quiet outputs in the cycle after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (nmi_n && cs_out == '0));
endmodule

// File: tb/priv_cs_unit_bench.sv
`timescale 1ns/1ps
module priv_cs_unit_bench;
    localparam logic [15:0] BASE = 16'hBF80;
    localparam logic [15:0] A_ST = BASE;
    localparam logic [15:0] A_DB = BASE + 16'd1;
    localparam logic [15:0] A_MK = BASE + 16'd2;

    logic        clk = 1'b0;
    logic        rst;
    logic        phi2;
    logic        rw;
    logic [15:0] addr;
    logic [7:0]  din;
    logic [7:0]  dout;
    logic        dout_en;
    logic [7:0]  cs_in;
    logic [7:0]  cs_out;
    logic        nmi_n;

    int vec = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    priv_cs_unit #(.WIN_BASE(BASE)) u_priv_cs_unit (
        .clk(clk), .rst(rst), .phi2(phi2), .rw(rw), .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en), .cs_in(cs_in), .cs_out(cs_out), .nmi_n(nmi_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    endtask

    // drive at a falling edge, return at the next falling edge
    task automatic step(input logic [15:0] a, input logic r, input logic [7:0] d,
                        input logic [7:0] cs, input logic ph);
        addr = a; rw = r; din = d; cs_in = cs; phi2 = ph;
        @(negedge clk);
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] exp, input logic en,
                      input string req);
        addr = a; rw = 1'b1; din = 8'h00; cs_in = 8'h00; phi2 = 1'b1;
        #1;
        chk(req, {23'd0, dout_en, dout}, {23'd0, en, exp});
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        $display("FAIL watchdog actual=running expected=finished");
        bad++;
        summary();
    end

    initial begin
        logic exp_viol;
        logic [7:0] m;
        rst = 1'b1; phi2 = 1'b0; rw = 1'b1; addr = 16'h0000; din = 8'h00; cs_in = 8'h00;
        @(negedge clk);
        step(16'h0000, 1'b1, 8'h00, 8'hFF, 1'b1);
        step(16'h0000, 1'b1, 8'h00, 8'h00, 1'b0);
        rst = 1'b0;

        // R1 reset state
        chk("R1 nmi", {31'd0, nmi_n}, 32'd1);
        chk("R1 cs", {24'd0, cs_out}, 32'd0);
        rd(A_ST, 8'h01, 1'b1, "R1 status");
        rd(A_MK, 8'hFF, 1'b1, "R1 mask");

        // R2 window decode
        rd(BASE + 16'd8, 8'h00, 1'b0, "R2 above window");
        rd(BASE - 16'd1, 8'h00, 1'b0, "R2 below window");
        rd(A_DB, 8'h00, 1'b1, "R2 doorbell reads zero");
        rd(BASE + 16'd3, 8'h00, 1'b1, "R2 offset3");
        rd(BASE + 16'd7, 8'h00, 1'b1, "R2 offset7");

        // R3 R4 R5 R6 R8 sweep
        for (int mi = 0; mi < 16; mi++) begin
            for (int p = 0; p < 2; p++) begin
                m = 8'(mi * 17);
                step(A_DB, 1'b0, 8'h00, 8'h00, 1'b1);
                step(A_MK, 1'b0, m, 8'h00, 1'b1);
                step(A_ST, 1'b0, {6'd0, 1'b1, p[0]}, 8'h00, 1'b1);
                exp_viol = 1'b0;
                for (int cs = 0; cs < 256; cs++) begin
                    addr = A_ST; rw = 1'b1; din = 8'h00; cs_in = 8'(cs); phi2 = 1'b1;
                    #1;
                    chk("R6 R8 status during sweep", {24'd0, dout},
                        {30'd0, exp_viol, p[0]});
                    @(negedge clk);
                    if (p[0])
                        chk("R4 privileged pass", {24'd0, cs_out}, {24'd0, 8'(cs)});
                    else
                        chk("R3 R4 gating", {24'd0, cs_out}, {24'd0, 8'(cs) & ~m});
                    if (!p[0] && ((8'(cs) & m) != 8'h00))
                        exp_viol = 1'b1;
                end
                rd(A_ST, {6'd0, exp_viol, p[0]}, 1'b1, "R6 sticky after sweep");
            end
        end

        // R5: no select after a phi2-low cycle
        step(A_DB, 1'b0, 8'h00, 8'h00, 1'b1);
        step(16'h0000, 1'b1, 8'h00, 8'hFF, 1'b0);
        chk("R5 idle phi2", {24'd0, cs_out}, 32'd0);
        step(16'h0000, 1'b1, 8'h00, 8'hA5, 1'b1);
        chk("R5 qualified", {24'd0, cs_out}, 32'hA5);

        // R9: unprivileged writes ignored, set violation
        step(A_MK, 1'b0, 8'h0F, 8'h00, 1'b1);
        step(A_ST, 1'b0, 8'h02, 8'h00, 1'b1);
        rd(A_ST, 8'h00, 1'b1, "R8 dropped privilege");
        step(A_MK, 1'b0, 8'h00, 8'h00, 1'b1);
        rd(A_MK, 8'h0F, 1'b1, "R9 mask unchanged");
        rd(A_ST, 8'h02, 1'b1, "R9 violation from mask write");
        step(A_ST, 1'b0, 8'h03, 8'h00, 1'b1);
        rd(A_ST, 8'h02, 1'b1, "R9 status write ignored");

        // R7 doorbell from unprivileged state
        chk("R7 idle nmi", {31'd0, nmi_n}, 32'd1);
        step(A_DB, 1'b0, 8'h00, 8'h00, 1'b1);
        chk("R7 nmi after write", {31'd0, nmi_n}, 32'd0);
        step(16'h0000, 1'b1, 8'h00, 8'h00, 1'b1);
        chk("R7 nmi after q1", {31'd0, nmi_n}, 32'd0);
        step(16'h0000, 1'b1, 8'h00, 8'h00, 1'b0);
        chk("R7 nmi over phi2 low", {31'd0, nmi_n}, 32'd0);
        step(16'h0000, 1'b1, 8'h00, 8'h00, 1'b1);
        chk("R7 nmi released", {31'd0, nmi_n}, 32'd1);
        rd(A_ST, 8'h03, 1'b1, "R7 privilege set, R6 flag kept");

        // R6 clear, R10 phi2-low writes
        step(A_ST, 1'b0, 8'h03, 8'h00, 1'b1);
        rd(A_ST, 8'h01, 1'b1, "R6 cleared");
        step(A_MK, 1'b0, 8'h55, 8'h00, 1'b0);
        rd(A_MK, 8'h0F, 1'b1, "R10 mask write without phi2");
        step(A_DB, 1'b0, 8'h00, 8'h00, 1'b0);
        chk("R10 doorbell without phi2", {31'd0, nmi_n}, 32'd1);
        step(A_ST, 1'b0, 8'h00, 8'h00, 1'b1);
        step(16'h0000, 1'b1, 8'h00, 8'h01, 1'b0);
        rd(A_ST, 8'h00, 1'b1, "R10 no violation without phi2");

        summary();
    end
endmodule